// File: doc/BRIEF.md
# Monochrome Rectangle Pixel Expander

This block fills a rectangle in an 8-bit-per-pixel frame buffer from a stream of one-bit mask words supplied by a host. A command word arms it. At that moment it captures the corner, the size of the rectangle, the foreground colour, the frame start address and the line pitch. It then takes mask words one at a time. Each mask bit covers one pixel of the rectangle, walked left to right and then top to bottom. A set bit produces a write strobe that carries the colour byte and the linear address of that pixel. A clear bit produces no strobe, but the walk still moves on by one pixel.

Mask words may be 8, 16 or 32 bits wide. An optional byte exchange can be applied inside each 16-bit half of a word before its bits are examined. One mask bit is consumed per clock. While a word is being consumed the block tells the host it is not ready. When the last pixel of the rectangle has been visited, the block drops its busy flag and discards any mask bits still left in the word.

Top module: `mono_rect_expander`

## Requirements
- R1: A command is accepted only in a cycle where `cmd_valid` is high and `cmd_word` bit 8 is 1. From the next cycle `busy` and `mask_ready` are 1. A command with bit 8 equal to 0 changes nothing.
- R2: Bits 10:9 of the accepted command select the mask word size: 0 gives the low 8 bits, 1 gives the low 16 bits, and 2 or 3 give all 32 bits.
- R3: If command bit 12 is 1, each mask word is rearranged to {w[23:16], w[31:24], w[7:0], w[15:8]} before its bits are selected.
- R4: A word is taken only while `mask_ready` is 1. After that, its bits are used one per clock from bit N-1 down to bit 0, and `mask_ready` stays 0 until the last bit has been used.
- R5: For each bit used, `pix_we` is 1 on the next cycle exactly when the bit is 1. When it is 1, `pix_data` equals the low 8 bits of the `fg_colour` value captured at the command.
- R6: The pixel address is `disp_start + line_len*Y + X` modulo 2^AW, where (X, Y) is the current walk position. The walk starts at (`cur_x`, `cur_y`).
- R7: The width is inclusive. After the pixel at X = start X + `rect_w`, the walk returns X to start X and increases Y by one, even in the middle of a word.
- R8: After the pixel at X = start X + `rect_w` and Y = start Y + `rect_h`, `busy` falls on the next cycle and the rest of the word produces no writes.
- R9: A new command accepted while busy restarts the walk and drops any unused mask bits. Mask words offered while idle are ignored.
- R10: After reset, `busy`, `mask_ready` and `pix_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | CMDW | Command: bit 8 arms, bits 10:9 select the size, bit 12 enables the swap |
| cur_x | input | XW | Start X, captured at the command |
| cur_y | input | XW | Start Y, captured at the command |
| rect_w | input | XW | Inclusive width bound (pixels per row minus one) |
| rect_h | input | XW | Inclusive height bound (rows minus one) |
| fg_colour | input | FGW | Foreground colour; the low PW bits are written |
| disp_start | input | AW | Frame buffer start address |
| line_len | input | LW | Line pitch in pixels |
| mask_valid | input | 1 | Mask word offered |
| mask_word | input | 32 | Mask word |
| mask_ready | output | 1 | A mask word will be taken this cycle |
| busy | output | 1 | The engine is armed and the rectangle is not finished |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | AW | Pixel byte address |
| pix_data | output | PW | Pixel colour byte |

## Verification
The assertions assume that the rectangle inputs, the colour, the start address and the pitch matter only in the cycle where a command is accepted. They also assume that a mask word is held steady for the one cycle in which `mask_valid` and `mask_ready` are both high. The stimulus sets the geometry together with the command strobe. It raises `mask_valid` only at a falling edge where `mask_ready` is already high and drops it one cycle later. This lets the cycle model count exactly one word taken per handshake. Words sent while idle, commands without bit 8, and a re-arm in the middle of a word are driven on purpose to exercise the cases the block must ignore or drop.

// File: rtl/rexp_pkg.sv
package rexp_pkg;

  localparam int MASK_W       = 32;
  localparam int CNT_W        = $clog2(MASK_W + 1);
  localparam int CMD_ARM_BIT  = 8;
  localparam int CMD_SIZE_LO  = 9;
  localparam int CMD_SWAP_BIT = 12;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DRAW = 1'b1
  } rexp_state_t;

  // Exchange the two bytes held in each 16-bit half.
  function automatic logic [MASK_W-1:0] swap_halves(input logic [MASK_W-1:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  // Mask bits per word for a size code; codes 2 and 3 both mean 32.
  function automatic logic [CNT_W-1:0] bits_for_code(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(8);
      2'd1:    return CNT_W'(16);
      default: return CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/rexp_mask_shifter.sv
module rexp_mask_shifter
  import rexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              shift,
  input  logic [MASK_W-1:0] word,
  input  logic [1:0]        size_code,
  input  logic              swap,
  output logic              bit_out,
  output logic              empty
);

  logic [MASK_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MASK_W-1:0] arranged;
  logic [CNT_W-1:0]  nbits;

  assign arranged = swap ? swap_halves(word) : word;
  assign nbits    = bits_for_code(size_code);
  assign bit_out  = sh_q[MASK_W-1];
  assign empty    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= arranged << (CNT_W'(MASK_W) - nbits);
      cnt_q <= nbits;
    end else if (shift) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: a fresh word is only loaded once the previous one is used up
  assert_load_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> empty);

  // R4: one bit used per clock
  assert_one_bit_per_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (shift && !flush && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: a loaded word holds 8, 16 or 32 bits
  assert_word_size_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |=> (cnt_q == 8 || cnt_q == 16 || cnt_q == 32));

endmodule

// File: rtl/rexp_walker.sv
module rexp_walker #(
  parameter int XW = 12,
  parameter int AW = 20,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          step,
  input  logic [XW-1:0] start_x,
  input  logic [XW-1:0] start_y,
  input  logic [XW-1:0] width,
  input  logic [XW-1:0] height,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] line_len,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam int CW = XW + 1;
  localparam int PW = LW + XW;

  logic [CW-1:0] sx_q, wx_q, xend_q, wy_q, yend_q;
  logic [LW-1:0] line_q;
  logic [AW-1:0] row_q;
  logic [PW-1:0] row_prod;
  logic          row_end;

  assign row_prod = line_len * start_y;
  assign row_end  = (wx_q == xend_q);
  assign last     = row_end && (wy_q == yend_q);
  assign addr     = row_q + AW'(wx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sx_q   <= '0;
      wx_q   <= '0;
      xend_q <= '0;
      wy_q   <= '0;
      yend_q <= '0;
      line_q <= '0;
      row_q  <= '0;
    end else if (arm) begin
      sx_q   <= CW'(start_x);
      wx_q   <= CW'(start_x);
      xend_q <= CW'(start_x) + CW'(width);
      wy_q   <= CW'(start_y);
      yend_q <= CW'(start_y) + CW'(height);
      line_q <= line_len;
      row_q  <= base + AW'(row_prod);
    end else if (step) begin
      if (row_end) begin
        wx_q  <= sx_q;
        wy_q  <= wy_q + 1'b1;
        row_q <= row_q + AW'(line_q);
      end else begin
        wx_q  <= wx_q + 1'b1;
      end
    end
  end

  // R7: X stays inside the inclusive row bounds
  assert_x_in_row_R7: assert property (@(posedge clk) disable iff (rst)
    (wx_q >= sx_q) && (wx_q <= xend_q));

  // R7: passing the right edge returns to the start column
  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !arm && row_end) |=> (wx_q == sx_q));

  // R6: inside a row the address moves on by one per pixel
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !arm && !row_end) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/mono_rect_expander.sv
module mono_rect_expander
  import rexp_pkg::*;
#(
  parameter int XW   = 12,
  parameter int AW   = 20,
  parameter int LW   = 12,
  parameter int FGW  = 16,
  parameter int PW   = 8,
  parameter int CMDW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMDW-1:0]   cmd_word,
  input  logic [XW-1:0]     cur_x,
  input  logic [XW-1:0]     cur_y,
  input  logic [XW-1:0]     rect_w,
  input  logic [XW-1:0]     rect_h,
  input  logic [FGW-1:0]    fg_colour,
  input  logic [AW-1:0]     disp_start,
  input  logic [LW-1:0]     line_len,
  input  logic              mask_valid,
  input  logic [MASK_W-1:0] mask_word,
  output logic              mask_ready,
  output logic              busy,
  output logic              pix_we,
  output logic [AW-1:0]     pix_addr,
  output logic [PW-1:0]     pix_data
);

  rexp_state_t   state_q;
  logic [1:0]    size_q;
  logic          swap_q;
  logic [PW-1:0] colour_q;
  logic          arm, take, shift, finish, flush;
  logic          empty, cur_bit, last_pos;
  logic [AW-1:0] walk_addr;
  logic          unused_inputs;

  assign unused_inputs = ^{cmd_word[CMDW-1:CMD_SWAP_BIT+1], cmd_word[CMD_SWAP_BIT-1:CMD_SIZE_LO+2],
                           cmd_word[CMD_ARM_BIT-1:0], fg_colour[FGW-1:PW]};

  assign arm    = cmd_valid && cmd_word[CMD_ARM_BIT];
  assign busy   = (state_q == ST_DRAW);
  assign take   = busy && empty && mask_valid && !arm;
  assign shift  = busy && !empty && !arm;
  assign finish = shift && last_pos;
  assign flush  = arm || finish;
  assign mask_ready = busy && empty;

  rexp_mask_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .load      (take),
    .shift     (shift),
    .word      (mask_word),
    .size_code (size_q),
    .swap      (swap_q),
    .bit_out   (cur_bit),
    .empty     (empty)
  );

  rexp_walker #(.XW(XW), .AW(AW), .LW(LW)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .step     (shift),
    .start_x  (cur_x),
    .start_y  (cur_y),
    .width    (rect_w),
    .height   (rect_h),
    .base     (disp_start),
    .line_len (line_len),
    .addr     (walk_addr),
    .last     (last_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      size_q   <= '0;
      swap_q   <= 1'b0;
      colour_q <= '0;
      pix_we   <= 1'b0;
      pix_addr <= '0;
      pix_data <= '0;
    end else begin
      pix_we <= shift && cur_bit;
      if (shift) begin
        pix_addr <= walk_addr;
        pix_data <= colour_q;
      end
      if (arm) begin
        state_q  <= ST_DRAW;
        size_q   <= cmd_word[CMD_SIZE_LO+1:CMD_SIZE_LO];
        swap_q   <= cmd_word[CMD_SWAP_BIT];
        colour_q <= fg_colour[PW-1:0];
      end else if (finish) begin
        state_q  <= ST_IDLE;
      end
    end
  end

  // R1: an accepted command leaves the engine busy and ready for a word
  assert_arm_ready_R1: assert property (@(posedge clk) disable iff (rst)
    arm |=> (busy && mask_ready));

  // R4: words are only asked for while armed
  assert_ready_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mask_ready |-> busy);

  // R5: no pixel strobe unless the engine was drawing
  assert_we_while_drawing_R5: assert property (@(posedge clk) disable iff (rst)
    pix_we |-> $past(busy));

  // R8: busy drops only after the final pixel was visited
  assert_idle_on_finish_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(finish));

endmodule

// File: tb/sim_mono_rect_expander.sv
module sim_mono_rect_expander;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [11:0] cur_x = '0, cur_y = '0, rect_w = '0, rect_h = '0, line_len = '0;
  logic [15:0] fg_colour = '0;
  logic [19:0] disp_start = '0;
  logic        mask_valid = 1'b0;
  logic [31:0] mask_word = '0;
  logic        mask_ready, busy, pix_we;
  logic [19:0] pix_addr;
  logic [7:0]  pix_data;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  // behavioural reference state
  int m_busy = 0, m_we = 0, m_addr = 0, m_data = 0;
  int m_sx, m_wx, m_wy, m_xe, m_ye, m_line, m_start, m_col, m_size, m_swap;
  bit m_q[$];
  int wlog[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_rect_expander u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cur_x(cur_x), .cur_y(cur_y), .rect_w(rect_w), .rect_h(rect_h),
    .fg_colour(fg_colour), .disp_start(disp_start), .line_len(line_len),
    .mask_valid(mask_valid), .mask_word(mask_word), .mask_ready(mask_ready),
    .busy(busy), .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit b;
    logic [31:0] w;
    int n;
    started = 1;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst) begin
      m_busy = 0; m_we = 0; m_addr = 0; m_data = 0; m_q.delete();
    end else begin
      m_we = 0;
      if (cmd_valid && cmd_word[8]) begin
        m_busy = 1; m_q.delete();
        m_sx = int'(cur_x); m_wx = m_sx; m_wy = int'(cur_y);
        m_xe = m_sx + int'(rect_w); m_ye = m_wy + int'(rect_h);
        m_line = int'(line_len); m_start = int'(disp_start);
        m_col = int'(fg_colour) & 255; m_size = int'(cmd_word[10:9]); m_swap = int'(cmd_word[12]);
      end else if (m_busy != 0 && m_q.size() > 0) begin
        b = m_q.pop_front();
        m_we = int'(b);
        m_addr = (m_start + m_line * m_wy + m_wx) % (1 << AW);
        m_data = m_col;
        if (m_wx == m_xe) begin
          if (m_wy == m_ye) begin m_busy = 0; m_q.delete(); end
          else begin m_wx = m_sx; m_wy++; end
        end else m_wx++;
      end else if (m_busy != 0 && mask_valid) begin
        n = (m_size == 0) ? 8 : (m_size == 1) ? 16 : 32;
        w = mask_word;
        if (m_swap != 0) w = {w[23:16], w[31:24], w[7:0], w[15:8]};
        for (int i = n - 1; i >= 0; i--) m_q.push_back(w[i]);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(pix_we == m_we[0], "R5 we", int'(pix_we), m_we);
      check(busy == m_busy[0], "R8 busy", int'(busy), m_busy);
      check(mask_ready == (m_busy != 0 && m_q.size() == 0), "R4 ready",
            int'(mask_ready), int'(m_busy != 0 && m_q.size() == 0));
      if (m_we != 0) begin
        check(int'(pix_addr) == m_addr, "R6 addr", int'(pix_addr), m_addr);
        check(int'(pix_data) == m_data, "R5 data", int'(pix_data), m_data);
      end
      if (pix_we) wlog.push_back(int'(pix_addr));
    end
  end

  task automatic command(input logic [15:0] c, input int x, input int y, input int w,
                         input int h, input int ln, input int st);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = c;
    cur_x = 12'(x); cur_y = 12'(y); rect_w = 12'(w); rect_h = 12'(h);
    line_len = 12'(ln); disp_start = 20'(st);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!mask_ready) @(negedge clk);
    mask_valid = 1'b1; mask_word = w;
    @(negedge clk);
    mask_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_log(input string req, input int exp[$]);
    check(wlog.size() == exp.size(), req, wlog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < wlog.size(); i++)
      check(wlog[i] == exp[i], req, wlog[i], exp[i]);
    wlog.delete();
  endtask

  initial begin
    fg_colour = 16'hAB55;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!busy && !mask_ready && !pix_we, "R10 reset", int'({busy, mask_ready, pix_we}), 0);

    // R1: bit 8 clear is ignored
    command(16'h1600, 0, 0, 3, 3, 8, 0);
    check(!busy, "R1 no arm", int'(busy), 0);
    // R9: word while idle is ignored
    mask_valid = 1'b1; mask_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    mask_valid = 1'b0;
    check(wlog.size() == 0, "R9 idle word", wlog.size(), 0);

    // R6 R7 R8: 8-bit words, 4x2 rectangle, upper bits ignored (R2)
    command(16'h0100, 2, 1, 3, 1, 16, 'h100);
    check(busy && mask_ready, "R1 armed", int'({busy, mask_ready}), 3);
    send(32'hDEAD_BEA5);
    wait_idle();
    expect_log("R7 8-bit walk", '{'h112, 'h114, 'h123, 'h125});
    check(!busy, "R8 idle", int'(busy), 0);

    // R3: swapped 16-bit word
    command(16'h1300, 0, 0, 15, 0, 32, 0);
    send(32'h0000_8001);
    wait_idle();
    expect_log("R3 swap", '{7, 8});
    // R4: unswapped, MSB first
    command(16'h0300, 0, 0, 15, 0, 32, 0);
    send(32'h0000_8001);
    wait_idle();
    expect_log("R4 msb first", '{0, 15});

    // R2 R8: size code 3 acts as 32, rest of the word dropped
    command(16'h0700, 4, 2, 3, 0, 10, 0);
    send(32'hF0FF_FFFF);
    wait_idle();
    expect_log("R8 leftover dropped", '{24, 25, 26, 27});

    // R7: multi-row walk wrapping mid-word, 30 pixels over 4 words
    command(16'h0100, 1, 3, 9, 2, 40, 'h2000);
    for (int k = 0; k < 4; k++) send(32'h0000_00FF);
    wait_idle();
    check(wlog.size() == 30, "R7 count", wlog.size(), 30);
    wlog.delete();

    // R9: re-arm mid-word drops pending bits
    command(16'h0500, 0, 0, 63, 3, 64, 0);
    send(32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    command(16'h0100, 5, 5, 7, 0, 64, 0);
    check(mask_ready && !pix_we, "R9 rearm", int'({mask_ready, pix_we}), 2);
    wlog.delete();
    send(32'h0000_0081);
    wait_idle();
    expect_log("R9 restart", '{325, 332});

    // R5: mixed pattern, colour change
    fg_colour = 16'h3C7E;
    command(16'h0300, 0, 0, 4, 3, 5, 'h40);
    send(32'h0000_A5C3);
    send(32'h0000_0F0F);
    wait_idle();
    check(!busy, "R8 final idle", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule